// File: doc/BRIEF.md
# Remote DMA Data Port with Completion Interrupt

This block lets a host move packet data to and from a byte-addressed packet memory through one data port, without handling memory addresses itself. Software first loads a 16-bit current address and a 16-bit remaining byte count through a small 8-bit register interface. Each access on the data port then reads or writes memory at the current address, moves the address forward and lowers the count. When the count is used up, a completion flag is raised in an interrupt status register. A configuration bit picks byte-wide or little-endian word-wide transfers.

The current address follows a ring in memory. When an advance lands exactly on the ring's end page, it jumps back to the ring's first page. Only two address ranges reach memory: a small identity area at the bottom and a packet window. Accesses outside both ranges still advance the address and count, but they never touch memory. Status bits are cleared by writing ones. A mask selects which of bits 6..0 drive the level interrupt output. Other units can set status bits 5..0 through an event input.

Top module: `rdma_port`

## Requirements
- R1: After reset, register 0x7 (status) reads 0x80, register 0x0 (command) reads 0x01, the count reads 0 and `irq` is low.
- R2: The address is loaded through its low byte at register 0x3 and its high byte at register 0x4. The count is loaded through its low byte at 0x5 and its high byte at 0x6. Each write replaces only its own byte, and reading the same offsets returns the current values.
- R3: With bit 0 of register 0x9 clear (byte mode), each data-port access moves the address up by 1 and the count down by 1. A write stores `dp_wdata[7:0]` in memory byte lane `addr[0]` (lane 1 is `mem_wdata[15:8]`). A read returns the byte in `dp_rdata[7:0]` with zeros above it.
- R4: With bit 0 of register 0x9 set (word mode), the memory access uses the address with bit 0 forced to 0, in little-endian order (the even byte is bits 7..0). The address register itself moves up by 2 from its current value, and the count moves down by 2.
- R5: If the advanced address equals the ring end page (register 0x2) times 256, it is replaced by the ring first page (register 0x1) times 256.
- R6: If the count before an access is less than or equal to the transfer width, the count becomes 0 and status bit 6 (transfer done) is set. Otherwise the count drops by the width.
- R7: A data-port write while the count is 0 is ignored: there is no memory request, and the address, count and status stay unchanged. A data-port read at count 0 still takes place and sets status bit 6.
- R8: Writing the command register with bit 0 (halt) clear, bit 1 or bit 2 (read or write request) set, and the count at 0 sets status bit 6 at the next clock edge. With halt set, the same write sets nothing.
- R9: A command write with bit 0 clear clears status bit 7 (reset indication). Nothing but reset sets that bit again.
- R10: Memory is accessed only at byte addresses below 32 or in the range 0x4000 to 0x7FFF. Outside those ranges, reads return 0x00FF (byte mode) or 0xFFFF (word mode), and writes make no memory request. Address and count still advance.
- R11: `irq` is high exactly when status AND mask (register 0x8) AND 0x7F is non-zero. Status bit 7 never raises it.
- R12: Writing register 0x7 clears each status bit among 6..0 that is written as 1. Bit 7 is not affected.
- R13: A high bit n of `ext_evt` (n = 0..5) in a cycle sets status bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data, valid with `dp_rvalid` |
| dp_rvalid | output | 1 | High the cycle after an accepted read |
| ext_evt | input | 6 | Pulses that set status bits 5..0 |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a register write and a data-port strobe never fall in the same cycle, and that `dp_rd` and `dp_wr` are never high together. Under that assumption, each completion or zero-length event can be tied to a single cause. The assertions also assume that memory answers a read request on the next cycle. The bench tasks raise exactly one strobe at a falling edge and drop it at the next falling edge. The bench memory model returns read data on the clock edge after the request, which matches the one-cycle assumption.

// File: rtl/rdma_pkg.sv
// Shared constants for the remote DMA data port: register offsets,
// command bit positions and status bit positions.
// Assumes an 8-bit register bus with a 4-bit offset.
package rdma_pkg;
    localparam int REG_AW = 4;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] RG_CMD        = 4'h0;
    localparam logic [REG_AW-1:0] RG_RING_FIRST = 4'h1;
    localparam logic [REG_AW-1:0] RG_RING_END   = 4'h2;
    localparam logic [REG_AW-1:0] RG_ADDR_LO    = 4'h3;
    localparam logic [REG_AW-1:0] RG_ADDR_HI    = 4'h4;
    localparam logic [REG_AW-1:0] RG_CNT_LO     = 4'h5;
    localparam logic [REG_AW-1:0] RG_CNT_HI     = 4'h6;
    localparam logic [REG_AW-1:0] RG_STAT       = 4'h7;
    localparam logic [REG_AW-1:0] RG_MASK       = 4'h8;
    localparam logic [REG_AW-1:0] RG_DCFG       = 4'h9;

    localparam int CMD_W    = 3;
    localparam int CMD_HALT = 0;
    localparam int CMD_RREQ = 1;
    localparam int CMD_WREQ = 2;

    localparam int EVT_W   = 6;
    localparam int ST_DONE = 6;
    localparam int ST_RSTF = 7;
    localparam int ST_IRQW = 7;
endpackage

// File: rtl/rdma_regs.sv
// Control register file and read multiplexer for the remote DMA port.
// It holds the command bits, ring pages, transfer mode and interrupt mask,
// and produces one-cycle write strobes for registers kept in other units.
// Assumes at most one register write per cycle.
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [REG_DW-1:0]     reg_wdata,
    output logic [REG_DW-1:0]     reg_rdata,
    input  logic [ADDR_W-1:0]     cur_addr,
    input  logic [CNT_W-1:0]      cur_cnt,
    input  logic [REG_DW-1:0]     stat_q,
    output logic [ADDR_W-9:0]     ring_first,
    output logic [ADDR_W-9:0]     ring_end,
    output logic                  word_mode,
    output logic [REG_DW-1:0]     mask_q,
    output logic                  wr_cmd,
    output logic                  wr_addr_lo,
    output logic                  wr_addr_hi,
    output logic                  wr_cnt_lo,
    output logic                  wr_cnt_hi,
    output logic                  wr_stat
);
    localparam int PAGE_W = ADDR_W - 8;

    logic [CMD_W-1:0] cmd_q;

    // Decode per-register write strobes.
    always_comb begin
        wr_cmd     = reg_wr && (reg_addr == RG_CMD);
        wr_addr_lo = reg_wr && (reg_addr == RG_ADDR_LO);
        wr_addr_hi = reg_wr && (reg_addr == RG_ADDR_HI);
        wr_cnt_lo  = reg_wr && (reg_addr == RG_CNT_LO);
        wr_cnt_hi  = reg_wr && (reg_addr == RG_CNT_HI);
        wr_stat    = reg_wr && (reg_addr == RG_STAT);
    end

    // Hold the locally owned control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_W'(1 << CMD_HALT);
            ring_first <= '0;
            ring_end   <= '0;
            word_mode  <= 1'b0;
            mask_q     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RG_CMD:        cmd_q      <= reg_wdata[CMD_W-1:0];
                RG_RING_FIRST: ring_first <= reg_wdata[PAGE_W-1:0];
                RG_RING_END:   ring_end   <= reg_wdata[PAGE_W-1:0];
                RG_MASK:       mask_q     <= reg_wdata;
                RG_DCFG:       word_mode  <= reg_wdata[0];
                default:       ;
            endcase
        end
    end

    // Select the register addressed by reg_addr for read-back.
    always_comb begin
        case (reg_addr)
            RG_CMD:        reg_rdata = REG_DW'(cmd_q);
            RG_RING_FIRST: reg_rdata = REG_DW'(ring_first);
            RG_RING_END:   reg_rdata = REG_DW'(ring_end);
            RG_ADDR_LO:    reg_rdata = cur_addr[7:0];
            RG_ADDR_HI:    reg_rdata = REG_DW'(cur_addr[ADDR_W-1:8]);
            RG_CNT_LO:     reg_rdata = cur_cnt[7:0];
            RG_CNT_HI:     reg_rdata = REG_DW'(cur_cnt[CNT_W-1:8]);
            RG_STAT:       reg_rdata = stat_q;
            RG_MASK:       reg_rdata = mask_q;
            RG_DCFG:       reg_rdata = {7'b0, word_mode};
            default:       reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rdma_engine.sv
// Transfer engine: keeps the current address and remaining count, turns
// data-port strobes into memory requests, and formats read data.
// Assumes a synchronous memory that returns read data one cycle after a
// request, and that dp_rd and dp_wr are not high together.
// A register write to address or count wins over a same-cycle step.
module rdma_engine #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PROM_BYTES = 32,
    parameter int WIN_BASE   = 'h4000,
    parameter int WIN_END    = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic [ADDR_W-9:0] ring_first,
    input  logic [ADDR_W-9:0] ring_end,
    input  logic              wr_addr_lo,
    input  logic              wr_addr_hi,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic [7:0]        reg_byte,
    input  logic              dp_wr,
    input  logic              dp_rd,
    input  logic [15:0]       dp_wdata,
    output logic [15:0]       dp_rdata,
    output logic              dp_rvalid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              done_evt
);
    localparam int LANES = 2;
    localparam int HI_A  = ADDR_W - 8;
    localparam int HI_C  = CNT_W - 8;
    localparam int CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] LIM_PROM = CMP_W'(PROM_BYTES);
    localparam logic [CMP_W-1:0] LIM_BASE = CMP_W'(WIN_BASE);
    localparam logic [CMP_W-1:0] LIM_END  = CMP_W'(WIN_END);

    logic [ADDR_W-1:0] addr_q, acc_addr, addr_adv, addr_nxt, wrap_at, wrap_to;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic [ADDR_W-1:0] step_a;
    logic [CNT_W-1:0]  step_c;
    logic              write_go, read_go, step, in_win, last;
    logic              rd_pend_q, rd_lane_q, rd_word_q, rd_miss_q;

    // Decide whether this cycle moves the engine.
    always_comb begin
        write_go = dp_wr && (cnt_q != '0);
        read_go  = dp_rd && !dp_wr;
        step     = write_go || read_go;
    end

    // Form the memory byte address and check it against the two windows.
    always_comb begin
        acc_addr = word_mode ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
        in_win   = ({1'b0, acc_addr} < LIM_PROM) ||
                   (({1'b0, acc_addr} >= LIM_BASE) && ({1'b0, acc_addr} < LIM_END));
    end

    // Compute the advanced address with ring wrap and the next count.
    always_comb begin
        step_a   = word_mode ? ADDR_W'(2) : ADDR_W'(1);
        step_c   = word_mode ? CNT_W'(2) : CNT_W'(1);
        wrap_at  = {ring_end, 8'h00};
        wrap_to  = {ring_first, 8'h00};
        addr_adv = addr_q + step_a;
        addr_nxt = (addr_adv == wrap_at) ? wrap_to : addr_adv;
        last     = (cnt_q <= step_c);
        cnt_nxt  = last ? '0 : (cnt_q - step_c);
        done_evt = step && last;
    end

    // Drive the memory request fields.
    always_comb begin
        mem_req  = step && in_win;
        mem_we   = write_go;
        mem_addr = acc_addr[ADDR_W-1:1];
    end

    // Per-lane enables and write data: word mode fills both lanes,
    // byte mode picks the lane named by address bit 0.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign mem_be[ln] = word_mode || (acc_addr[0] == 1'(ln));
        assign mem_wdata[8*ln +: 8] = word_mode ? dp_wdata[8*ln +: 8] : dp_wdata[7:0];
    end

    // Address register: register writes first, then transfer steps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (wr_addr_lo)
            addr_q[7:0] <= reg_byte;
        else if (wr_addr_hi)
            addr_q[ADDR_W-1:8] <= reg_byte[HI_A-1:0];
        else if (step)
            addr_q <= addr_nxt;
    end

    // Count register: register writes first, then transfer steps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_cnt_lo)
            cnt_q[7:0] <= reg_byte;
        else if (wr_cnt_hi)
            cnt_q[CNT_W-1:8] <= reg_byte[HI_C-1:0];
        else if (step)
            cnt_q <= cnt_nxt;
    end

    // Remember the shape of an issued read until its data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_lane_q <= 1'b0;
            rd_word_q <= 1'b0;
            rd_miss_q <= 1'b0;
        end else begin
            rd_pend_q <= read_go;
            rd_lane_q <= acc_addr[0];
            rd_word_q <= word_mode;
            rd_miss_q <= !in_win;
        end
    end

    // Format returned data: byte pick, word pass-through, or all ones.
    always_comb begin
        dp_rvalid = rd_pend_q;
        if (rd_miss_q)
            dp_rdata = rd_word_q ? 16'hFFFF : 16'h00FF;
        else if (rd_word_q)
            dp_rdata = mem_rdata;
        else
            dp_rdata = {8'h00, rd_lane_q ? mem_rdata[15:8] : mem_rdata[7:0]};
    end

    assign cur_addr = addr_q;
    assign cur_cnt  = cnt_q;
endmodule

// File: rtl/rdma_irq.sv
// Interrupt status register and level interrupt output.
// Bits 6..0 are set by events and cleared by writing ones. Bit 7 marks
// reset and is cleared by a command write that leaves halt off.
// A set event in the same cycle as a clear wins.
module rdma_irq
    import rdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [ST_IRQW-1:0] clr_bits,
    input  logic             wr_cmd,
    input  logic [CMD_W-1:0] cmd_bits,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic             done_evt,
    input  logic [EVT_W-1:0] ext_evt,
    input  logic [ST_IRQW-1:0] mask_bits,
    output logic [7:0]       stat_q,
    output logic             irq
);
    logic             run_cmd, zero_len;
    logic [ST_IRQW-1:0] set_v, clr_v;

    // Work out which status bits to set and which to clear this cycle.
    always_comb begin
        run_cmd  = wr_cmd && !cmd_bits[CMD_HALT];
        zero_len = run_cmd && (cmd_bits[CMD_RREQ] || cmd_bits[CMD_WREQ]) &&
                   (cur_cnt == '0);
        set_v    = {done_evt || zero_len, ext_evt};
        clr_v    = wr_stat ? clr_bits : '0;
    end

    // Update the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 8'h80;
        end else begin
            stat_q[ST_IRQW-1:0] <= (stat_q[ST_IRQW-1:0] & ~clr_v) | set_v;
            if (run_cmd)
                stat_q[ST_RSTF] <= 1'b0;
        end
    end

    // Drive the level interrupt from the masked low status bits.
    assign irq = |(stat_q[ST_IRQW-1:0] & mask_bits);
endmodule

// File: rtl/rdma_port.sv
// Top of the remote DMA data port: register file, transfer engine and
// interrupt status unit.
// Assumes one strobe per cycle among register write, data-port read
// and data-port write.
module rdma_port
    import rdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PROM_BYTES = 32,
    parameter int WIN_BASE   = 'h4000,
    parameter int WIN_END    = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dp_wr,
    input  logic              dp_rd,
    input  logic [15:0]       dp_wdata,
    output logic [15:0]       dp_rdata,
    output logic              dp_rvalid,
    input  logic [5:0]        ext_evt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              irq
);
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [7:0]        stat_q, mask_q;
    logic [ADDR_W-9:0] ring_first, ring_end;
    logic              word_mode, done_evt;
    logic              wr_cmd, wr_addr_lo, wr_addr_hi, wr_cnt_lo, wr_cnt_hi, wr_stat;

    rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .stat_q(stat_q), .ring_first(ring_first),
        .ring_end(ring_end), .word_mode(word_mode), .mask_q(mask_q),
        .wr_cmd(wr_cmd), .wr_addr_lo(wr_addr_lo), .wr_addr_hi(wr_addr_hi),
        .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi), .wr_stat(wr_stat)
    );

    rdma_engine #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PROM_BYTES(PROM_BYTES),
        .WIN_BASE(WIN_BASE), .WIN_END(WIN_END)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
        .ring_first(ring_first), .ring_end(ring_end),
        .wr_addr_lo(wr_addr_lo), .wr_addr_hi(wr_addr_hi),
        .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi), .reg_byte(reg_wdata),
        .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata),
        .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .done_evt(done_evt)
    );

    rdma_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat),
        .clr_bits(reg_wdata[ST_IRQW-1:0]), .wr_cmd(wr_cmd),
        .cmd_bits(reg_wdata[CMD_W-1:0]), .cur_cnt(cur_cnt),
        .done_evt(done_evt), .ext_evt(ext_evt),
        .mask_bits(mask_q[ST_IRQW-1:0]), .stat_q(stat_q), .irq(irq)
    );
endmodule

// File: rtl/rdma_port_chk.sv
// Property checker for rdma_port, attached to it with bind.
// Assumes a register write and a data-port strobe never share a cycle.
module rdma_port_chk
    import rdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PROM_BYTES = 32,
    parameter int WIN_BASE   = 'h4000,
    parameter int WIN_END    = 'h8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [3:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              dp_wr,
    input logic              dp_rd,
    input logic              mem_req,
    input logic [ADDR_W-2:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic              irq,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [7:0]        stat_q,
    input logic [7:0]        mask_q,
    input logic              word_mode
);
    localparam int CMP_W = ADDR_W + 1;
    logic [CMP_W-1:0] byte_a;
    logic [CNT_W-1:0] width;
    logic             stepping, zl_cmd;

    // Helper terms shared by several properties.
    always_comb begin
        byte_a   = {1'b0, mem_addr, 1'b0};
        width    = word_mode ? CNT_W'(2) : CNT_W'(1);
        stepping = (dp_wr && cur_cnt != '0) || (dp_rd && !dp_wr);
        zl_cmd   = reg_wr && (reg_addr == RG_CMD) && !reg_wdata[CMD_HALT] &&
                   (reg_wdata[CMD_RREQ] || reg_wdata[CMD_WREQ]) && (cur_cnt == '0);
    end

    AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !reg_wr && cur_cnt <= width) |=> (cur_cnt == '0 && stat_q[ST_DONE])); // R6
    AST_IDLE_WRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && cur_cnt == '0) |-> !mem_req); // R7
    AST_IDLE_WRITE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && cur_cnt == '0 && !reg_wr) |=> $stable(cur_addr)); // R7
    AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        zl_cmd |=> stat_q[ST_DONE]); // R8
    AST_RESET_FLAG_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(stat_q[ST_RSTF])); // R9
    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (byte_a < CMP_W'(PROM_BYTES) ||
                     (byte_a >= CMP_W'(WIN_BASE) && byte_a < CMP_W'(WIN_END)))); // R10
    AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && word_mode) |-> (mem_be == 2'b11)); // R4
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !word_mode) |-> ($countones(mem_be) == 1)); // R3
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((mask_q & 8'h7F) != 8'h00)); // R11
endmodule

bind rdma_port rdma_port_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PROM_BYTES(PROM_BYTES),
    .WIN_BASE(WIN_BASE), .WIN_END(WIN_END)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dp_wr(dp_wr), .dp_rd(dp_rd), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_be(mem_be), .irq(irq), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .stat_q(stat_q), .mask_q(mask_q), .word_mode(word_mode)
);

// File: tb/rdma_port_test.sv
// Self-checking bench for rdma_port: a vector table of single transfers,
// then directed tests for reset, data values, windows and interrupts.
module rdma_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_wr = 1'b0, dp_rd = 1'b0;
    logic [15:0] dp_wdata = 16'h0;
    logic [15:0] dp_rdata;
    logic        dp_rvalid;
    logic [5:0]  ext_evt = 6'h0;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int mem_writes = 0;
    logic [15:0] bmem [int];
    logic [15:0] wtmp;

    rdma_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr),
        .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .dp_rvalid(dp_rvalid), .ext_evt(ext_evt), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memory model with byte enables.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                wtmp = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 16'h0;
                if (mem_be[0]) wtmp[7:0]  = mem_wdata[7:0];
                if (mem_be[1]) wtmp[15:8] = mem_wdata[15:8];
                bmem[int'(mem_addr)] = wtmp;
                mem_writes++;
            end else begin
                mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 16'h0;
            end
        end
    end

    typedef struct packed {
        logic        wm;
        logic [15:0] a;
        logic [15:0] c;
        logic [7:0]  pf;
        logic [7:0]  pe;
        logic [15:0] ea;
        logic [15:0] ec;
        logic        ed;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b0, 16'h4000, 16'd5,  8'h40, 8'h60, 16'h4001, 16'd4, 1'b0}, // R3
        '{1'b1, 16'h4010, 16'd6,  8'h40, 8'h60, 16'h4012, 16'd4, 1'b0}, // R4
        '{1'b0, 16'h5FFF, 16'd3,  8'h46, 8'h60, 16'h4600, 16'd2, 1'b0}, // R5
        '{1'b1, 16'h5FFE, 16'd10, 8'h46, 8'h60, 16'h4600, 16'd8, 1'b0}, // R5
        '{1'b0, 16'h4020, 16'd1,  8'h40, 8'h60, 16'h4021, 16'd0, 1'b1}, // R6
        '{1'b1, 16'h4024, 16'd2,  8'h40, 8'h60, 16'h4026, 16'd0, 1'b1}, // R6
        '{1'b1, 16'h4030, 16'd1,  8'h40, 8'h60, 16'h4032, 16'd0, 1'b1}, // R6
        '{1'b1, 16'h4041, 16'd4,  8'h40, 8'h60, 16'h4043, 16'd2, 1'b0}  // R4
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rreg(lo, l);
        rreg(lo + 4'h1, h);
        v = {h, l};
    endtask

    task automatic setup(input logic wm, input logic [15:0] a, input logic [15:0] c);
        wreg(4'h9, {7'b0, wm});
        wreg(4'h3, a[7:0]);
        wreg(4'h4, a[15:8]);
        wreg(4'h5, c[7:0]);
        wreg(4'h6, c[15:8]);
    endtask

    task automatic dpw(input logic [15:0] d);
        @(negedge clk);
        dp_wr = 1'b1; dp_wdata = d;
        @(negedge clk);
        dp_wr = 1'b0;
    endtask

    task automatic dpr(output logic [15:0] d, output logic v);
        @(negedge clk);
        dp_rd = 1'b1;
        @(negedge clk);
        dp_rd = 1'b0;
        #1;
        d = dp_rdata;
        v = dp_rvalid;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk);
        ext_evt = e;
        @(negedge clk);
        ext_evt = 6'h0;
    endtask

    function automatic logic [15:0] peek(input int w);
        return bmem.exists(w) ? bmem[w] : 16'h0;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        logic        v;
        int          snap;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rreg(4'h7, b); check("R1 status after reset", 16'(b), 16'h0080);
        rreg(4'h0, b); check("R1 command after reset", 16'(b), 16'h0001);
        rd16(4'h5, w); check("R1 count after reset", w, 16'h0000);
        check("R1 irq after reset", 16'(irq), 16'h0);

        // R11 bit 7 never drives irq
        wreg(4'h8, 8'h80);
        check("R11 reset flag masked out", 16'(irq), 16'h0);
        // R12 status write leaves bit 7
        wreg(4'h7, 8'hFF);
        rreg(4'h7, b); check("R12 bit7 kept on clear", 16'(b), 16'h0080);
        // R9 running command clears bit 7
        wreg(4'h0, 8'h00);
        rreg(4'h7, b); check("R9 reset flag cleared", 16'(b), 16'h0000);
        wreg(4'h8, 8'h00);

        // R2 byte-wise loads
        wreg(4'h5, 8'h34); wreg(4'h6, 8'h12);
        rd16(4'h5, w); check("R2 count load", w, 16'h1234);
        wreg(4'h5, 8'h56);
        rd16(4'h5, w); check("R2 low write keeps high", w, 16'h1256);
        wreg(4'h4, 8'h47); wreg(4'h3, 8'h21); wreg(4'h4, 8'h48);
        rd16(4'h3, w); check("R2 address high write keeps low", w, 16'h4821);

        // Table of single-transfer vectors (R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            wreg(4'h7, 8'h7F);
            wreg(4'h1, VT[i].pf);
            wreg(4'h2, VT[i].pe);
            setup(VT[i].wm, VT[i].a, VT[i].c);
            dpw(16'hA5A5);
            rd16(4'h3, w); check($sformatf("R3/R4/R5 vec%0d address", i), w, VT[i].ea);
            rd16(4'h5, w); check($sformatf("R3/R4/R6 vec%0d count", i), w, VT[i].ec);
            rreg(4'h7, b); check($sformatf("R6 vec%0d done bit", i), 16'(b[6]), 16'(VT[i].ed));
        end

        // R3 byte lane data
        wreg(4'h1, 8'h40); wreg(4'h2, 8'h60);
        setup(1'b0, 16'h4101, 16'd2);
        dpw(16'h77C3);
        check("R3 odd byte lands in upper lane", peek(16'h4100 >> 1), 16'hC300);
        setup(1'b0, 16'h4101, 16'd2);
        dpr(w, v);
        check("R3 byte read value", w, 16'h00C3);
        check("R3 read valid", 16'(v), 16'h1);

        // R4 word data, even-forced, little endian
        setup(1'b1, 16'h4201, 16'd4);
        dpw(16'hBEEF);
        check("R4 word write even address", peek(16'h4200 >> 1), 16'hBEEF);
        setup(1'b0, 16'h4200, 16'd1);
        dpr(w, v); check("R4 low byte at even address", w, 16'h00EF);
        setup(1'b0, 16'h4201, 16'd1);
        dpr(w, v); check("R4 high byte at odd address", w, 16'h00BE);
        setup(1'b1, 16'h4201, 16'd2);
        dpr(w, v); check("R4 word read", w, 16'hBEEF);

        // R7 writes ignored at zero count, reads still run
        wreg(4'h7, 8'h7F);
        setup(1'b0, 16'h4300, 16'd0);
        snap = mem_writes;
        dpw(16'h0011);
        check("R7 no memory write at zero count", 16'(mem_writes - snap), 16'h0);
        rd16(4'h3, w); check("R7 address unchanged", w, 16'h4300);
        rreg(4'h7, b); check("R7 status unchanged", 16'(b), 16'h0000);
        dpr(w, v);
        rd16(4'h3, w); check("R7 read at zero count advances", w, 16'h4301);
        rreg(4'h7, b); check("R7 read at zero count completes", 16'(b), 16'h0040);

        // R8 zero-length commands
        wreg(4'h7, 8'h7F);
        wreg(4'h0, 8'h02);
        rreg(4'h7, b); check("R8 read request at zero count", 16'(b), 16'h0040);
        wreg(4'h7, 8'h7F);
        wreg(4'h0, 8'h04);
        rreg(4'h7, b); check("R8 write request at zero count", 16'(b), 16'h0040);
        wreg(4'h7, 8'h7F);
        wreg(4'h0, 8'h03);
        rreg(4'h7, b); check("R8 halted command sets nothing", 16'(b), 16'h0000);
        wreg(4'h0, 8'h00);
        rreg(4'h7, b); check("R8 no request sets nothing", 16'(b), 16'h0000);
        wreg(4'h5, 8'h05);
        wreg(4'h0, 8'h02);
        rreg(4'h7, b); check("R8 nonzero count sets nothing", 16'(b), 16'h0000);

        // R10 address windows
        setup(1'b0, 16'h001F, 16'd4);
        snap = mem_writes;
        dpw(16'h005A);
        check("R10 write at 0x1F reaches memory", 16'(mem_writes - snap), 16'h1);
        check("R10 data at 0x1F", peek(16'h000F), 16'h5A00);
        snap = mem_writes;
        dpw(16'h005B);
        check("R10 write at 0x20 discarded", 16'(mem_writes - snap), 16'h0);
        rd16(4'h5, w); check("R10 count still advances", w, 16'd2);
        setup(1'b0, 16'h8000, 16'd4);
        snap = mem_writes;
        dpw(16'h005C);
        check("R10 write at 0x8000 discarded", 16'(mem_writes - snap), 16'h0);
        setup(1'b0, 16'h7FFF, 16'd4);
        snap = mem_writes;
        dpw(16'h005D);
        check("R10 write at 0x7FFF reaches memory", 16'(mem_writes - snap), 16'h1);
        setup(1'b0, 16'h1000, 16'd4);
        dpr(w, v); check("R10 byte read outside windows", w, 16'h00FF);
        setup(1'b1, 16'h1000, 16'd4);
        dpr(w, v); check("R10 word read outside windows", w, 16'hFFFF);

        // R13 events, R11 masking, R12 selective clear
        wreg(4'h7, 8'h7F);
        pulse_evt(6'b000001);
        rreg(4'h7, b); check("R13 event bit0", 16'(b), 16'h0001);
        check("R11 irq low with mask clear", 16'(irq), 16'h0);
        wreg(4'h8, 8'h01);
        check("R11 irq high when masked bit set", 16'(irq), 16'h1);
        pulse_evt(6'b100000);
        rreg(4'h7, b); check("R13 event bit5", 16'(b), 16'h0021);
        wreg(4'h7, 8'h01);
        rreg(4'h7, b); check("R12 clears only written ones", 16'(b), 16'h0020);
        check("R11 irq drops after clear", 16'(irq), 16'h0);
        wreg(4'h5, 8'h00);
        wreg(4'h0, 8'h02);
        wreg(4'h8, 8'h40);
        check("R11 irq on done bit", 16'(irq), 16'h1);
        wreg(4'h7, 8'h40);
        rreg(4'h7, b); check("R12 done cleared, event kept", 16'(b), 16'h0020);
        check("R11 irq after done clear", 16'(irq), 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule